// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block collects error indications from the surrounding logic into a 64-bit fault register. Each bit can be masked, and each is sorted into a severity class by a pair of action registers. Software reaches the bank over a simple 64-bit register bus with a write strobe, a register index and combinational read data. The fault register and the mask each have three addresses. One overwrites the register, one ANDs the write data into it, and one ORs the write data into it. Software can therefore clear or set chosen bits without a read-modify-write.

Hardware fault inputs are ORed into the fault register on every clock, after any bus write in the same cycle. A capture register records the first unmasked fault pattern seen while it is empty. Any bus write to the capture register empties it again. Three attention outputs report unmasked faults by class: recoverable, special and checkstop.

The bank also holds two more registers. A mode register stores only its top byte, and a reset-control register stores only its top bit. Two error-report addresses take writes and discard them.

Top module: `fault_isolation_bank`

## Requirements
- R1: After reset every register reads 0 and all three attention outputs are low.
- R2: Index 0 overwrites the fault register, index 1 ANDs the write data into it, and index 2 ORs the write data into it. All three indices read back the fault register. A write takes effect at the clock edge that ends the write cycle.
- R3: Index 3 overwrites the mask register, index 4 ANDs the write data into it, and index 5 ORs the write data into it. All three indices read back the mask.
- R4: Index 6 (action A) and index 7 (action B) are plain read/write registers.
- R5: The hwFault bits are ORed into the fault register at every clock edge, after any bus write to the fault register in that cycle. A bit that hardware sets in the same cycle as an overwrite or AND-clear write therefore ends up set.
- R6: While the capture register (index 8) is zero, it loads the unmasked fault bits (fault AND NOT mask) at the first edge where they are nonzero. Because this uses the stored fault value, it happens one edge after the fault register changes. While nonzero, the capture register holds its value.
- R7: Any write to index 8 clears the capture register to zero, whatever the write data. The clear takes priority over a load in the same cycle.
- R8: A write to the mode register (index 9) keeps only bits 63:56. All other bits read 0.
- R9: A write to the reset-control register (index 10) keeps only bit 63.
- R10: Writes to the error-report indices 11 and 12, and to unmapped indices 13 to 15, change no register. These indices read 0.
- R11: For each unmasked fault bit i: if action A bit i is 1, checkstopAttn is asserted; if action A bit i is 0 and action B bit i is 1, specialAttn is asserted; if both are 0, recoverAttn is asserted. The outputs depend only on the stored registers. A fully set mask keeps all three outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe for this cycle |
| regAddr | input | 4 | Register index for both read and write |
| wrData | input | 64 | Write data |
| hwFault | input | 64 | Per-bit hardware fault set, sampled every clock |
| rdData | output | 64 | Combinational read data of the indexed register |
| recoverAttn | output | 1 | Unmasked fault in the recoverable class |
| specialAttn | output | 1 | Unmasked fault in the special class |
| checkstopAttn | output | 1 | Unmasked fault in the checkstop class |

## Verification
Bus writes and hardware fault pulses are registered at the rising edge that ends their cycle. The bench drives each stimulus for one full cycle starting at a falling edge and reads the register at the following falling edge. Read data and the attention outputs are combinational from the stored registers, so the bench samples them one nanosecond after setting the index, at that same falling edge. A fault that hardware sets reaches the capture register one edge after it reaches the fault register. The capture checks therefore wait one extra falling edge after the pulse, and they also check that the capture value holds on the cycles after that.

// File: rtl/fib_pkg.sv
package fib_pkg;

  localparam int IDX_FAULT     = 0;
  localparam int IDX_FAULT_AND = 1;
  localparam int IDX_FAULT_OR  = 2;
  localparam int IDX_MASK      = 3;
  localparam int IDX_MASK_AND  = 4;
  localparam int IDX_MASK_OR   = 5;
  localparam int IDX_ACTA      = 6;
  localparam int IDX_ACTB      = 7;
  localparam int IDX_CAPTURE   = 8;
  localparam int IDX_MODE      = 9;
  localparam int IDX_RSTCTL    = 10;
  localparam int IDX_ERRREP0   = 11;
  localparam int IDX_ERRREP1   = 12;

  typedef struct packed {
    logic faultWr;
    logic faultAnd;
    logic faultOr;
    logic maskWr;
    logic maskAnd;
    logic maskOr;
    logic actAWr;
    logic actBWr;
    logic captureClr;
    logic modeWr;
    logic rstCtlWr;
  } strobeT;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FAULT,
    SEL_MASK,
    SEL_ACTA,
    SEL_ACTB,
    SEL_CAPTURE,
    SEL_MODE,
    SEL_RSTCTL
  } rdSelE;

endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobeT            strb,
  output rdSelE             rdSel
);

  // Write decode: at most one strobe per cycle, none without wrEn.
  // Error-report and unmapped indices raise no strobe.
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regAddr)
        ADDR_W'(IDX_FAULT):     strb.faultWr    = 1'b1;
        ADDR_W'(IDX_FAULT_AND): strb.faultAnd   = 1'b1;
        ADDR_W'(IDX_FAULT_OR):  strb.faultOr    = 1'b1;
        ADDR_W'(IDX_MASK):      strb.maskWr     = 1'b1;
        ADDR_W'(IDX_MASK_AND):  strb.maskAnd    = 1'b1;
        ADDR_W'(IDX_MASK_OR):   strb.maskOr     = 1'b1;
        ADDR_W'(IDX_ACTA):      strb.actAWr     = 1'b1;
        ADDR_W'(IDX_ACTB):      strb.actBWr     = 1'b1;
        ADDR_W'(IDX_CAPTURE):   strb.captureClr = 1'b1;
        ADDR_W'(IDX_MODE):      strb.modeWr     = 1'b1;
        ADDR_W'(IDX_RSTCTL):    strb.rstCtlWr   = 1'b1;
        default:                strb = '0;
      endcase
    end
  end

  // Read select: aliases read back their base register
  always_comb begin
    case (regAddr)
      ADDR_W'(IDX_FAULT),
      ADDR_W'(IDX_FAULT_AND),
      ADDR_W'(IDX_FAULT_OR):  rdSel = SEL_FAULT;
      ADDR_W'(IDX_MASK),
      ADDR_W'(IDX_MASK_AND),
      ADDR_W'(IDX_MASK_OR):   rdSel = SEL_MASK;
      ADDR_W'(IDX_ACTA):      rdSel = SEL_ACTA;
      ADDR_W'(IDX_ACTB):      rdSel = SEL_ACTB;
      ADDR_W'(IDX_CAPTURE):   rdSel = SEL_CAPTURE;
      ADDR_W'(IDX_MODE):      rdSel = SEL_MODE;
      ADDR_W'(IDX_RSTCTL):    rdSel = SEL_RSTCTL;
      default:                rdSel = SEL_NONE;
    endcase
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (strb == '0));

endmodule

// File: rtl/fib_datapath.sv
module fib_datapath
  import fib_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int MODE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  rdSelE             rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] hwFault,
  output logic [DATA_W-1:0] rdData,
  output logic              recoverAttn,
  output logic              specialAttn,
  output logic              checkstopAttn
);

  localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] MODE_KEEP = ~(ALL_ONES >> MODE_BITS);
  localparam logic [DATA_W-1:0] RST_KEEP  = ~(ALL_ONES >> 1);

  logic [DATA_W-1:0] faultQ, faultBus, faultD;
  logic [DATA_W-1:0] maskQ, maskD;
  logic [DATA_W-1:0] actAQ, actBQ;
  logic [DATA_W-1:0] captureQ, captureD;
  logic [DATA_W-1:0] modeQ, rstCtlQ;
  logic [DATA_W-1:0] unmasked;

  // Fault register: bus operation first, hardware set on top
  always_comb begin
    faultBus = faultQ;
    if (strb.faultWr)       faultBus = wrData;
    else if (strb.faultAnd) faultBus = faultQ & wrData;
    else if (strb.faultOr)  faultBus = faultQ | wrData;
    faultD = faultBus | hwFault;
  end

  always_comb begin
    maskD = maskQ;
    if (strb.maskWr)       maskD = wrData;
    else if (strb.maskAnd) maskD = maskQ & wrData;
    else if (strb.maskOr)  maskD = maskQ | wrData;
  end

  assign unmasked = faultQ & ~maskQ;

  // Capture: clear wins; load only while empty
  always_comb begin
    if (strb.captureClr)     captureD = '0;
    else if (captureQ == '0) captureD = unmasked;
    else                     captureD = captureQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      faultQ   <= '0;
      maskQ    <= '0;
      actAQ    <= '0;
      actBQ    <= '0;
      captureQ <= '0;
      modeQ    <= '0;
      rstCtlQ  <= '0;
    end else begin
      faultQ   <= faultD;
      maskQ    <= maskD;
      captureQ <= captureD;
      if (strb.actAWr)   actAQ   <= wrData;
      if (strb.actBWr)   actBQ   <= wrData;
      if (strb.modeWr)   modeQ   <= wrData & MODE_KEEP;
      if (strb.rstCtlWr) rstCtlQ <= wrData & RST_KEEP;
    end
  end

  // Severity classes from the action pair
  assign checkstopAttn = |(unmasked & actAQ);
  assign specialAttn   = |(unmasked & ~actAQ & actBQ);
  assign recoverAttn   = |(unmasked & ~actAQ & ~actBQ);

  always_comb begin
    case (rdSel)
      SEL_FAULT:   rdData = faultQ;
      SEL_MASK:    rdData = maskQ;
      SEL_ACTA:    rdData = actAQ;
      SEL_ACTB:    rdData = actBQ;
      SEL_CAPTURE: rdData = captureQ;
      SEL_MODE:    rdData = modeQ;
      SEL_RSTCTL:  rdData = rstCtlQ;
      default:     rdData = '0;
    endcase
  end

  // R5
  hw_fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|hwFault) |=> ((faultQ & $past(hwFault)) == $past(hwFault)));

  // R6
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((captureQ != '0) && !strb.captureClr) |=> (captureQ == $past(captureQ)));

  // R7
  capture_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strb.captureClr |=> (captureQ == '0));

  // R11
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (maskQ == ALL_ONES) |-> !(recoverAttn || specialAttn || checkstopAttn));

  // R9
  rstctl_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rstCtlWr |=> ((rstCtlQ & ~RST_KEEP) == '0));

endmodule

// File: rtl/fault_isolation_bank.sv
module fault_isolation_bank
  import fib_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 4,
  parameter int MODE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] hwFault,
  output logic [DATA_W-1:0] rdData,
  output logic              recoverAttn,
  output logic              specialAttn,
  output logic              checkstopAttn
);

  strobeT strb;
  rdSelE  rdSel;

  fib_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  fib_datapath #(.DATA_W(DATA_W), .MODE_BITS(MODE_BITS)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strb          (strb),
    .rdSel         (rdSel),
    .wrData        (wrData),
    .hwFault       (hwFault),
    .rdData        (rdData),
    .recoverAttn   (recoverAttn),
    .specialAttn   (specialAttn),
    .checkstopAttn (checkstopAttn)
  );

endmodule

// File: tb/fault_isolation_bank_tb.sv
`timescale 1ns/1ps
module fault_isolation_bank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [63:0] wrData = '0;
  logic [63:0] hwFault = '0;
  logic [63:0] rdData;
  logic        recoverAttn, specialAttn, checkstopAttn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fault_isolation_bank u_dut (
    .clk           (clk),
    .rst           (rst),
    .wrEn          (wrEn),
    .regAddr       (regAddr),
    .wrData        (wrData),
    .hwFault       (hwFault),
    .rdData        (rdData),
    .recoverAttn   (recoverAttn),
    .specialAttn   (specialAttn),
    .checkstopAttn (checkstopAttn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [63:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic checkReg(input string req, input logic [3:0] a, input logic [63:0] exp);
    logic [63:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic checkAttn(input string req, input logic [2:0] exp);
    #1;
    check(req, {61'd0, checkstopAttn, specialAttn, recoverAttn}, {61'd0, exp});
  endtask

  task automatic hwPulse(input logic [63:0] bits);
    @(negedge clk);
    hwFault = bits;
    @(negedge clk);
    hwFault = '0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) checkReg("R1 reset read", 4'(i), 64'd0);
    checkAttn("R1 reset attention", 3'b000);
  endtask

  task automatic test_fault_alias();
    busWrite(4'd0, 64'hF0F0_0000_0000_00FF);
    checkReg("R2 overwrite", 4'd0, 64'hF0F0_0000_0000_00FF);
    busWrite(4'd1, 64'hFF00_0000_0000_000F);
    checkReg("R2 and-clear", 4'd0, 64'hF000_0000_0000_000F);
    busWrite(4'd2, 64'h0000_0000_0000_0F00);
    checkReg("R2 or-set", 4'd0, 64'hF000_0000_0000_0F0F);
    checkReg("R2 alias read idx1", 4'd1, 64'hF000_0000_0000_0F0F);
    checkReg("R2 alias read idx2", 4'd2, 64'hF000_0000_0000_0F0F);
    busWrite(4'd0, 64'd0);
    checkReg("R2 overwrite zero", 4'd0, 64'd0);
  endtask

  task automatic test_mask_alias();
    busWrite(4'd3, 64'h1234_5678_9ABC_DEF0);
    checkReg("R3 overwrite", 4'd3, 64'h1234_5678_9ABC_DEF0);
    busWrite(4'd4, 64'hFFFF_0000_FFFF_0000);
    checkReg("R3 and-clear", 4'd3, 64'h1234_0000_9ABC_0000);
    busWrite(4'd5, 64'h0000_0000_0000_000F);
    checkReg("R3 or-set", 4'd5, 64'h1234_0000_9ABC_000F);
    busWrite(4'd3, 64'd0);
    checkReg("R3 overwrite zero", 4'd4, 64'd0);
  endtask

  task automatic test_action();
    busWrite(4'd6, 64'hA5A5_A5A5_0000_FFFF);
    busWrite(4'd7, 64'h5A5A_5A5A_FFFF_0000);
    checkReg("R4 action A", 4'd6, 64'hA5A5_A5A5_0000_FFFF);
    checkReg("R4 action B", 4'd7, 64'h5A5A_5A5A_FFFF_0000);
    busWrite(4'd6, 64'd0);
    busWrite(4'd7, 64'd0);
    checkReg("R4 action A zero", 4'd6, 64'd0);
  endtask

  task automatic test_hw_order();
    @(negedge clk);
    wrEn = 1'b1; regAddr = 4'd0; wrData = 64'h0F; hwFault = 64'h100;
    @(negedge clk);
    wrEn = 1'b0; hwFault = '0;
    checkReg("R5 hw over overwrite", 4'd0, 64'h10F);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 4'd1; wrData = 64'd0; hwFault = 64'h1;
    @(negedge clk);
    wrEn = 1'b0; hwFault = '0;
    checkReg("R5 hw over and-clear", 4'd0, 64'h1);
    hwPulse(64'h8000_0000_0000_0000);
    checkReg("R5 hw pulse alone", 4'd0, 64'h8000_0000_0000_0001);
    busWrite(4'd0, 64'd0);
    checkReg("R5 cleanup", 4'd0, 64'd0);
  endtask

  task automatic test_capture();
    busWrite(4'd0, 64'd0);
    busWrite(4'd8, 64'h5);
    checkReg("R7 clear nonzero data", 4'd8, 64'd0);
    busWrite(4'd3, 64'hFF);
    hwPulse(64'h3);
    @(negedge clk);
    checkReg("R6 masked not captured", 4'd8, 64'd0);
    hwPulse(64'h300);
    checkReg("R6 not yet loaded", 4'd8, 64'd0);
    @(negedge clk);
    checkReg("R6 first capture", 4'd8, 64'h300);
    hwPulse(64'h1_0000);
    @(negedge clk);
    checkReg("R6 holds", 4'd8, 64'h300);
    busWrite(4'd0, 64'd0);
    busWrite(4'd8, 64'hDEAD);
    checkReg("R7 cleared", 4'd8, 64'd0);
    @(negedge clk);
    checkReg("R7 stays clear", 4'd8, 64'd0);
    busWrite(4'd3, 64'd0);
  endtask

  task automatic test_mode_rst();
    busWrite(4'd9, 64'hFFFF_FFFF_FFFF_FFFF);
    checkReg("R8 mode top byte", 4'd9, 64'hFF00_0000_0000_0000);
    busWrite(4'd10, 64'hFFFF_FFFF_FFFF_FFFF);
    checkReg("R9 rstctl bit63", 4'd10, 64'h8000_0000_0000_0000);
    busWrite(4'd10, 64'h7FFF_FFFF_FFFF_FFFF);
    checkReg("R9 rstctl low ignored", 4'd10, 64'd0);
  endtask

  task automatic test_ignored();
    busWrite(4'd0, 64'h55);
    busWrite(4'd11, 64'hFFFF_FFFF_FFFF_FFFF);
    busWrite(4'd12, 64'hFFFF_FFFF_FFFF_FFFF);
    busWrite(4'd15, 64'hFFFF_FFFF_FFFF_FFFF);
    checkReg("R10 errrep0 reads zero", 4'd11, 64'd0);
    checkReg("R10 errrep1 reads zero", 4'd12, 64'd0);
    checkReg("R10 unmapped reads zero", 4'd15, 64'd0);
    checkReg("R10 fault untouched", 4'd0, 64'h55);
    checkReg("R10 mask untouched", 4'd3, 64'd0);
    checkReg("R10 mode untouched", 4'd9, 64'hFF00_0000_0000_0000);
    checkReg("R10 actA untouched", 4'd6, 64'd0);
    busWrite(4'd0, 64'd0);
  endtask

  task automatic test_attention();
    busWrite(4'd6, 64'h1);
    busWrite(4'd7, 64'h3);
    busWrite(4'd0, 64'h1);
    checkAttn("R11 checkstop class", 3'b100);
    busWrite(4'd0, 64'h2);
    checkAttn("R11 special class", 3'b010);
    busWrite(4'd0, 64'h4);
    checkAttn("R11 recoverable class", 3'b001);
    busWrite(4'd0, 64'h7);
    checkAttn("R11 all classes", 3'b111);
    busWrite(4'd3, 64'h5);
    checkAttn("R11 partial mask", 3'b010);
    busWrite(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    checkAttn("R11 full mask", 3'b000);
    busWrite(4'd3, 64'd0);
    busWrite(4'd0, 64'd0);
    checkAttn("R11 no fault", 3'b000);
  endtask

  initial begin
    test_reset();
    test_fault_alias();
    test_mask_alias();
    test_action();
    test_hw_order();
    test_capture();
    test_mode_rst();
    test_ignored();
    test_attention();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule